// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each received frame, whether the frame is kept. It looks only at the frame's 48-bit destination address, which arrives on a bus with a one-cycle valid strobe. The address bus holds address byte 0 in bits 7:0 and byte 5 in bits 47:40. Three mechanisms vote. The first is a table of sixteen exact entries, each switched on by its own valid bit. The second is a 4096-bit multicast hash table, held as 128 words of 32 bits and indexed by twelve address bits. The third is a control word with broadcast accept, unicast promiscuous and multicast promiscuous flags.

Software programs the control word, the exact entries and the hash words through a plain 32-bit write port. A fixed two cycles after each strobe, the block gives one decision. That decision carries an accept flag and a flag saying the frame got through only on the inexact hash. The pipeline takes a new address in every cycle.

Top module: `rx_daddr_filter`

## Requirements
- R1: For every cycle with `da_valid` high, `dec_valid` is high for exactly one cycle, two cycles later. `dec_accept` and `dec_inexact` are low whenever `dec_valid` is low.
- R2: Exact entry i has its low word at config word address 0x40+2i and its high word at 0x41+2i. The low word holds address bits 31:0, with byte 0 in bits 7:0. The high word holds address bits 47:32 in bits 15:0. A non-broadcast address equal to a valid entry is accepted with `dec_inexact` low.
- R3: Bit 31 of an entry's high word is its valid bit. An entry whose last high-word write had bit 31 clear never matches.
- R4: The hash mode is control bits 13:12. Mode 0 takes index = address bits 47:36, mode 1 takes bits 46:35, mode 2 takes bits 45:34, and mode 3 takes bits 43:32. Index bits 11:5 pick hash word w, written at config address 0x80+w. Index bits 4:0 pick the bit within that word.
- R5: A multicast address is one with address bit 0 set and not all ones. If it misses every exact entry but its hash bit is set, it is accepted with `dec_inexact` high.
- R6: A multicast address that misses both the exact entries and the hash is accepted only if control bit 4 (multicast promiscuous) is set, and then with `dec_inexact` low.
- R7: A unicast address (bit 0 clear) that misses every exact entry is accepted only if control bit 3 (unicast promiscuous) is set. The hash table has no effect on unicast addresses.
- R8: The all-ones address is accepted if and only if control bit 15 (broadcast accept) is set, whatever the exact entries, hash and promiscuous flags hold. `dec_inexact` is low for it.
- R9: The control word is at config address 0x00. Writes to addresses 0x01 to 0x3F and 0x60 to 0x7F change nothing.
- R10: After reset, all entries are invalid, the hash table and the control word are zero, and every address is rejected.
- R11: A lookup uses the tables and control word as they stood before the clock edge that samples its strobe. A write on that same edge affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_inexact | output | 1 | Accepted through the hash only |

## Verification
The bench builds the block with its default parameters: sixteen exact entries, an 8-bit configuration address, entries at 0x40 and hash words at 0x80. This puts every entry, every hash word and all four index modes within reach of the address-map requirements. Directed cases cover the precedence of broadcast over exact match, and of exact match over hash. They also cover invalidating an entry, unmapped writes, and a write landing on the same edge as a strobe. A seeded random phase then interleaves writes with lookups of programmed, multicast, unicast and broadcast addresses, and checks each against a reference model kept in the bench.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int HASH_W     = 12;
  localparam int HASH_WORDS = 1 << (HASH_W - 5);

  localparam int CTRL_UPE_BIT  = 3;
  localparam int CTRL_MPE_BIT  = 4;
  localparam int CTRL_HSEL_LO  = 12;
  localparam int CTRL_BAM_BIT  = 15;
  localparam int ENTRY_VLD_BIT = 31;

  typedef enum logic [1:0] {
    HSEL_47_36 = 2'd0,
    HSEL_46_35 = 2'd1,
    HSEL_45_34 = 2'd2,
    HSEL_43_32 = 2'd3
  } hsel_e;

  typedef struct packed {
    logic  bcast_ok;
    logic  mcast_all;
    logic  ucast_all;
    hsel_e hsel;
  } rxf_ctrl_t;

  function automatic logic [HASH_W-1:0] hash_index(input logic [47:0] a, input hsel_e sel);
    case (sel)
      HSEL_47_36: return a[47:36];
      HSEL_46_35: return a[46:35];
      HSEL_45_34: return a[45:34];
      default:    return a[43:32];
    endcase
  endfunction

  function automatic logic is_bcast(input logic [47:0] a);
    return &a;
  endfunction

  function automatic logic is_group(input logic [47:0] a);
    return a[0];
  endfunction

  // returns {accept, inexact}
  function automatic logic [1:0] decide(input logic bcast, input logic group,
                                        input logic exact, input logic hhit,
                                        input rxf_ctrl_t c);
    if (bcast) return {c.bcast_ok, 1'b0};
    if (exact) return 2'b10;
    if (group) begin
      if (hhit) return 2'b11;
      return {c.mcast_all, 1'b0};
    end
    return {c.ucast_all, 1'b0};
  endfunction

endpackage

// File: rtl/rxf_ctrl_regs.sv
module rxf_ctrl_regs
  import rxf_pkg::*;
#(
  parameter int CFG_AW    = 8,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output rxf_ctrl_t         ctrl
);

  logic wr_ctrl;
  assign wr_ctrl = cfg_we && (int'(cfg_addr) == CTRL_ADDR);

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[31:16], cfg_wdata[14], cfg_wdata[11:5], cfg_wdata[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.bcast_ok  <= cfg_wdata[CTRL_BAM_BIT];
      ctrl.mcast_all <= cfg_wdata[CTRL_MPE_BIT];
      ctrl.ucast_all <= cfg_wdata[CTRL_UPE_BIT];
      ctrl.hsel      <= hsel_e'(cfg_wdata[CTRL_HSEL_LO+1:CTRL_HSEL_LO]);
    end
  end

endmodule

// File: rtl/rxf_exact_table.sv
module rxf_exact_table #(
  parameter int N_EXACT    = 16,
  parameter int CFG_AW     = 8,
  parameter int EXACT_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [47:0]       look_da,
  output logic [N_EXACT-1:0] hit_vec,
  output logic              hit
);

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[30:16];

  for (genvar i = 0; i < N_EXACT; i++) begin : g_ent
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic        vld_q;
    logic        wr_lo, wr_hi;

    assign wr_lo = cfg_we && (int'(cfg_addr) == EXACT_BASE + 2 * i);
    assign wr_hi = cfg_we && (int'(cfg_addr) == EXACT_BASE + 2 * i + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        vld_q <= 1'b0;
      end else begin
        if (wr_lo) lo_q <= cfg_wdata;
        if (wr_hi) begin
          hi_q  <= cfg_wdata[15:0];
          vld_q <= cfg_wdata[31];
        end
      end
    end

    assign hit_vec[i] = vld_q && (look_da == {hi_q, lo_q});
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table
  import rxf_pkg::*;
#(
  parameter int CFG_AW    = 8,
  parameter int HASH_BASE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [HASH_W-1:0] look_idx,
  output logic              hit
);

  localparam int WSEL_W = HASH_W - 5;

  logic [31:0]       mta_q [HASH_WORDS];
  logic              in_rng;
  logic [WSEL_W-1:0] widx;

  assign in_rng = cfg_we && (int'(cfg_addr) >= HASH_BASE) &&
                  (int'(cfg_addr) < HASH_BASE + HASH_WORDS);
  assign widx   = WSEL_W'(int'(cfg_addr) - HASH_BASE);

  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mta_q[w] <= '0;
      else if (in_rng && widx == WSEL_W'(w)) mta_q[w] <= cfg_wdata;
    end
  end

  assign hit = mta_q[look_idx[HASH_W-1:5]][look_idx[4:0]];

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      s1_valid,
  input  logic      s1_bcast,
  input  logic      s1_group,
  input  logic      s1_exact_hit,
  input  logic      s1_hash_hit,
  input  rxf_ctrl_t s1_ctrl,
  output logic      dec_valid,
  output logic      dec_accept,
  output logic      dec_inexact
);

  logic [1:0] res;
  assign res = decide(s1_bcast, s1_group, s1_exact_hit, s1_hash_hit, s1_ctrl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_accept  <= 1'b0;
      dec_inexact <= 1'b0;
    end else begin
      dec_valid   <= s1_valid;
      dec_accept  <= s1_valid && res[1];
      dec_inexact <= s1_valid && res[0];
    end
  end

endmodule

// File: rtl/rx_daddr_filter.sv
module rx_daddr_filter
  import rxf_pkg::*;
#(
  parameter int N_EXACT    = 16,
  parameter int CFG_AW     = 8,
  parameter int EXACT_BASE = 64,
  parameter int HASH_BASE  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              da_valid,
  input  logic [47:0]       da,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_inexact
);

  rxf_ctrl_t          ctrl;
  logic [N_EXACT-1:0] exact_vec;
  logic               exact_now;
  logic               hash_now;
  logic [HASH_W-1:0]  hidx;

  rxf_ctrl_regs #(.CFG_AW(CFG_AW), .CTRL_ADDR(0)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl(ctrl)
  );

  rxf_exact_table #(.N_EXACT(N_EXACT), .CFG_AW(CFG_AW), .EXACT_BASE(EXACT_BASE)) u_exact (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .look_da(da), .hit_vec(exact_vec), .hit(exact_now)
  );

  assign hidx = hash_index(da, ctrl.hsel);

  rxf_hash_table #(.CFG_AW(CFG_AW), .HASH_BASE(HASH_BASE)) u_hash (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .look_idx(hidx), .hit(hash_now)
  );

  logic unused_vec;
  assign unused_vec = ^exact_vec;

  // stage 1: lookup results and the control word seen by this address
  logic      s1_valid, s1_bcast, s1_group, s1_exact_hit, s1_hash_hit;
  rxf_ctrl_t s1_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid     <= 1'b0;
      s1_bcast     <= 1'b0;
      s1_group     <= 1'b0;
      s1_exact_hit <= 1'b0;
      s1_hash_hit  <= 1'b0;
      s1_ctrl      <= '0;
    end else begin
      s1_valid <= da_valid;
      if (da_valid) begin
        s1_bcast     <= is_bcast(da);
        s1_group     <= is_group(da);
        s1_exact_hit <= exact_now;
        s1_hash_hit  <= hash_now;
        s1_ctrl      <= ctrl;
      end
    end
  end

  // named wires for the checker
  logic s1_bam, s1_mpe, s1_upe;
  assign s1_bam = s1_ctrl.bcast_ok;
  assign s1_mpe = s1_ctrl.mcast_all;
  assign s1_upe = s1_ctrl.ucast_all;

  rxf_decide u_dec (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_bcast(s1_bcast),
    .s1_group(s1_group), .s1_exact_hit(s1_exact_hit), .s1_hash_hit(s1_hash_hit),
    .s1_ctrl(s1_ctrl), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_inexact(dec_inexact)
  );

endmodule

// File: rtl/rxf_filter_checker.sv
module rxf_filter_checker (
  input logic clk,
  input logic rst_n,
  input logic da_valid,
  input logic s1_valid,
  input logic s1_bcast,
  input logic s1_group,
  input logic s1_exact_hit,
  input logic s1_hash_hit,
  input logic s1_bam,
  input logic s1_mpe,
  input logic s1_upe,
  input logic dec_valid,
  input logic dec_accept,
  input logic dec_inexact
);

  assert_strobe_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> s1_valid);

  assert_stage_forward_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> dec_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !dec_valid);

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && !dec_inexact));

  assert_inexact_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_inexact |-> dec_accept);

  assert_exact_precedence_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_exact_hit && !s1_bcast) |=> (dec_accept && !dec_inexact));

  assert_hash_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_group && !s1_bcast && !s1_exact_hit && s1_hash_hit)
      |=> (dec_accept && dec_inexact));

  assert_mcast_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_group && !s1_bcast && !s1_exact_hit && !s1_hash_hit)
      |=> (dec_accept == $past(s1_mpe) && !dec_inexact));

  assert_ucast_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_group && !s1_exact_hit) |=> (dec_accept == $past(s1_upe)));

  assert_bcast_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_bcast) |=> (dec_accept == $past(s1_bam) && !dec_inexact));

endmodule

bind rx_daddr_filter rxf_filter_checker u_chk (
  .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .s1_valid(s1_valid),
  .s1_bcast(s1_bcast), .s1_group(s1_group), .s1_exact_hit(s1_exact_hit),
  .s1_hash_hit(s1_hash_hit), .s1_bam(s1_bam), .s1_mpe(s1_mpe), .s1_upe(s1_upe),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_inexact(dec_inexact)
);

// File: tb/rx_daddr_filter_tb_top.sv
module rx_daddr_filter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        da_valid = 1'b0;
  logic [47:0] da = '0;
  logic        dec_valid, dec_accept, dec_inexact;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_daddr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_inexact(dec_inexact)
  );

  // reference model state
  logic [31:0] m_lo  [16];
  logic [15:0] m_hi  [16];
  logic        m_v   [16];
  logic [31:0] m_mta [128];
  logic        m_upe, m_mpe, m_bam;
  logic [1:0]  m_mode;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 16; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_v[i] = 0; end
    for (int i = 0; i < 128; i++) m_mta[i] = 0;
    m_upe = 0; m_mpe = 0; m_bam = 0; m_mode = 0;
  endfunction

  function automatic void model_write(input int a, input logic [31:0] d);
    if (a == 0) begin
      m_upe = d[3]; m_mpe = d[4]; m_bam = d[15]; m_mode = d[13:12];
    end else if (a >= 64 && a < 96) begin
      if ((a - 64) % 2 == 0) m_lo[(a - 64) / 2] = d;
      else begin m_hi[(a - 64) / 2] = d[15:0]; m_v[(a - 64) / 2] = d[31]; end
    end else if (a >= 128 && a < 256) begin
      m_mta[a - 128] = d;
    end
  endfunction

  function automatic int idx_of(input logic [47:0] a);
    int sh;
    sh = (m_mode == 0) ? 36 : (m_mode == 1) ? 35 : (m_mode == 2) ? 34 : 32;
    return int'((a >> sh) & 48'hFFF);
  endfunction

  function automatic logic [1:0] expect_dec(input logic [47:0] a);
    bit ex = 0;
    int ix;
    if (a == BCAST) return {m_bam, 1'b0};
    for (int i = 0; i < 16; i++)
      if (m_v[i] && {m_hi[i], m_lo[i]} == a) ex = 1;
    if (ex) return 2'b10;
    if (a[0]) begin
      ix = idx_of(a);
      if (m_mta[ix / 32][ix % 32]) return 2'b11;
      return {m_mpe, 1'b0};
    end
    return {m_upe, 1'b0};
  endfunction

  task automatic cfg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[7:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic lookup(input logic [47:0] a, input string req);
    logic [1:0] e;
    e = expect_dec(a);
    @(negedge clk);
    da_valid = 1'b1; da = a;
    @(negedge clk);
    da_valid = 1'b0;
    chk("R1 early valid", {31'b0, dec_valid}, 0);
    @(negedge clk);
    chk("R1 valid at two cycles", {31'b0, dec_valid}, 1);
    chk(req, {30'b0, dec_accept, dec_inexact}, {30'b0, e});
  endtask

  task automatic set_hash_bit(input logic [47:0] a);
    int ix;
    ix = idx_of(a);
    cfg_write(128 + ix / 32, m_mta[ix / 32] | (32'h1 << (ix % 32)));
  endtask

  task automatic prog_entry(input int i, input logic [47:0] a, input bit v);
    cfg_write(64 + 2 * i, a[31:0]);
    cfg_write(65 + 2 * i, {v, 15'b0, a[47:32]});
  endtask

  function automatic logic [47:0] rnd48();
    return {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [47:0] a_ex, a_b, m1, u1;
    int seed_v;
    seed_v = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset outputs", {29'b0, dec_valid, dec_accept, dec_inexact}, 0);
    lookup(48'h0000_1234_5678, "R10 unicast after reset");
    lookup(48'h0000_0000_0001, "R10 multicast after reset");
    lookup(BCAST, "R10 broadcast after reset");

    // R2 exact entry
    a_ex = 48'hA1B2_C3D4_E5F6;
    prog_entry(3, a_ex, 1'b1);
    lookup(a_ex, "R2 exact hit");
    lookup(48'hF6E5_D4C3_B2A1, "R2 byte-swapped miss");
    a_b = 48'h0102_0304_0506;
    prog_entry(15, a_b, 1'b1);
    lookup(a_b, "R2 last entry hit");

    // R3 valid bit
    prog_entry(5, 48'h2222_3333_4444, 1'b0);
    lookup(48'h2222_3333_4444, "R3 invalid entry ignored");
    cfg_write(65 + 2 * 3, {1'b0, 15'b0, a_ex[47:32]});
    lookup(a_ex, "R3 invalidated entry");

    // R4/R5 hash in each mode
    for (int md = 0; md < 4; md++) begin
      cfg_write(0, md << 12);
      m1 = rnd48() | 48'h1;
      set_hash_bit(m1);
      lookup(m1, "R4 R5 hash hit per mode");
    end
    cfg_write(0, 32'h0);
    m1 = 48'h8C00_0000_0001;
    set_hash_bit(m1);
    lookup(m1, "R5 inexact pass");
    prog_entry(7, m1, 1'b1);
    lookup(m1, "R2 exact beats hash");

    // R6 multicast promiscuous
    lookup(48'h0300_0000_0103, "R6 mcast miss rejected");
    cfg_write(0, 32'h10);
    lookup(48'h0300_0000_0103, "R6 mcast promiscuous");

    // R7 unicast: hash has no effect
    cfg_write(0, 32'h0);
    u1 = 48'h8C00_0000_0002;
    set_hash_bit(u1 | 48'h1);
    lookup(u1, "R7 ucast hash ignored");
    cfg_write(0, 32'h8);
    lookup(u1, "R7 ucast promiscuous");

    // R8 broadcast gating
    prog_entry(9, BCAST, 1'b1);
    cfg_write(0, 32'h18);
    set_hash_bit(BCAST);
    lookup(BCAST, "R8 bcast rejected without accept bit");
    cfg_write(0, 32'h8000);
    lookup(BCAST, "R8 bcast accepted");

    // R9 unmapped writes
    cfg_write(0, 32'h0);
    cfg_write(8'h01, 32'hFFFF_FFFF);
    cfg_write(8'h3F, 32'hFFFF_FFFF);
    cfg_write(8'h60, 32'hFFFF_FFFF);
    cfg_write(8'h7F, 32'hFFFF_FFFF);
    lookup(48'h7777_0000_0000, "R9 unicast still rejected");
    lookup(48'h0500_0000_0011, "R9 mcast still rejected");
    lookup(BCAST, "R9 bcast still rejected");

    // R11 write on the strobe edge
    begin
      logic [1:0] e;
      u1 = 48'h4444_5555_6666;
      e = expect_dec(u1);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 8'h00; cfg_wdata = 32'h8;
      da_valid = 1'b1; da = u1;
      @(negedge clk);
      cfg_we = 1'b0; da_valid = 1'b0;
      model_write(0, 32'h8);
      @(negedge clk);
      chk("R11 same-edge write unseen", {30'b0, dec_accept, dec_inexact}, {30'b0, e});
      lookup(u1, "R11 write seen next lookup");
    end

    // seeded random phase
    for (int k = 0; k < 400; k++) begin
      int sel;
      sel = int'($urandom() % 10);
      if (sel == 0) cfg_write(0, $urandom() & 32'h0000_B018);
      else if (sel == 1) prog_entry(int'($urandom() % 16), rnd48(), 1'($urandom()));
      else if (sel == 2) cfg_write(128 + int'($urandom() % 128), $urandom());
      else if (sel == 3) begin
        int i;
        i = int'($urandom() % 16);
        lookup({m_hi[i], m_lo[i]}, "R2 R3 random entry");
      end
      else if (sel <= 6) lookup(rnd48() | 48'h1, "R5 R6 random multicast");
      else if (sel <= 8) lookup(rnd48() & ~48'h1, "R7 random unicast");
      else lookup(BCAST, "R8 random broadcast");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule